// File: doc/BRIEF.md
# Dual Priority Request Encoder

This block takes a vector of request lines and, in one combinational pass, reports two things: the position of the asserted request with the highest priority, and the position of the asserted request that ranks next below it. Request 7 ranks highest and request 0 ranks lowest. Each reported position has its own valid flag. When no requests are asserted, both flags are low. When exactly one request is asserted, only the first flag is high.

The block is a drop-in selector for any place that must pick two winners in the same cycle, such as dual-issue grant logic or two-port allocation. It has no clock and no stored state. The request count is a parameter, and the index width is derived from it.

Top module: `dual_prio_enc`

## Requirements
- R1: `top_vld_o` is 1 exactly when at least one bit of `req_i` is 1.
- R2: When `top_vld_o` is 1, `top_idx_o` is the position of the most significant 1 in `req_i`; bit 7 has the highest priority and bit 0 the lowest.
- R3: `next_vld_o` is 1 exactly when two or more bits of `req_i` are 1.
- R4: When `next_vld_o` is 1, `next_idx_o` is the position of the most significant 1 in `req_i` strictly below `top_idx_o`.
- R5: An index whose valid flag is 0 reads as 0.
- R6: While both flags are 1, `next_idx_o` is strictly less than `top_idx_o`, so the two indices never match.
- R7: For `req_i` = 8'b01001001, `top_idx_o` is 6 and `next_idx_o` is 3, with both flags 1.
- R8: The outputs follow a change of `req_i` with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | 8 | Request lines, one bit per requester |
| top_idx_o | output | 3 | Position of the highest-priority asserted request |
| top_vld_o | output | 1 | At least one request is asserted |
| next_idx_o | output | 3 | Position of the second-highest asserted request |
| next_vld_o | output | 1 | At least two requests are asserted |

## Verification
All 256 request patterns are applied, so several cases are covered together:
- The empty vector tells the both-invalid case apart from a real index 0.
- Single-bit vectors separate the first flag from the second.
- Vectors with adjacent set bits show whether the second scan really masks out the winner.
- Vectors with a set bit 0 under a higher bit check that the lowest position can be reported as second.

The named example pattern is checked on its own, and a run of input changes between clock edges confirms that no output waits for a clock.

// File: rtl/dual_prio_enc.sv
module dual_prio_enc #(
  parameter int NREQ = 8,
  localparam int IW = $clog2(NREQ)
) (
  input  logic [NREQ-1:0] req_i,
  output logic [IW-1:0]   top_idx_o,
  output logic            top_vld_o,
  output logic [IW-1:0]   next_idx_o,
  output logic            next_vld_o
);

  logic [NREQ-1:0] rest;

  always_comb begin
    top_idx_o = '0;
    top_vld_o = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (req_i[i]) begin
        top_idx_o = IW'(i);
        top_vld_o = 1'b1;
      end
    end
  end

  always_comb begin
    rest = req_i;
    if (top_vld_o) rest[top_idx_o] = 1'b0;
  end

  always_comb begin
    next_idx_o = '0;
    next_vld_o = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (rest[i]) begin
        next_idx_o = IW'(i);
        next_vld_o = 1'b1;
      end
    end
  end

endmodule

module dual_prio_enc_chk #(
  parameter int NREQ = 8,
  localparam int IW = $clog2(NREQ)
) (
  input logic [NREQ-1:0] req_i,
  input logic [IW-1:0]   top_idx_o,
  input logic            top_vld_o,
  input logic [IW-1:0]   next_idx_o,
  input logic            next_vld_o
);

  always_comb begin
    // R1
    top_vld_any_chk: assert (top_vld_o == (req_i != '0));
    // R3
    next_vld_count_chk: assert (next_vld_o == ($countones(req_i) >= 2));
    // R2
    top_is_msb_chk: assert (!top_vld_o || (req_i[top_idx_o] && ((req_i >> top_idx_o) == 1)));
    // R5
    top_idle_zero_chk: assert (top_vld_o || top_idx_o == '0);
    // R5
    next_idle_zero_chk: assert (next_vld_o || next_idx_o == '0);
    // R6
    order_distinct_chk: assert (!(top_vld_o && next_vld_o) || next_idx_o < top_idx_o);
    // R4
    next_is_set_chk: assert (!next_vld_o || req_i[next_idx_o]);
  end

endmodule

bind dual_prio_enc dual_prio_enc_chk #(.NREQ(NREQ)) u_chk (
  .req_i(req_i),
  .top_idx_o(top_idx_o),
  .top_vld_o(top_vld_o),
  .next_idx_o(next_idx_o),
  .next_vld_o(next_vld_o)
);

// File: tb/dual_prio_enc_tb.sv
module dual_prio_enc_tb;
  logic       clk = 1'b0;
  logic [7:0] req;
  logic [2:0] top_idx, next_idx;
  logic       top_vld, next_vld;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_prio_enc u_dut (
    .req_i(req), .top_idx_o(top_idx), .top_vld_o(top_vld),
    .next_idx_o(next_idx), .next_vld_o(next_vld)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s req=%b actual=%0d expected=%0d", tag, req, act, exp);
    end
  endtask

  initial begin
    req = '0;
    @(negedge clk);
    // R1 R5: empty vector
    chk("R1 empty top_vld", top_vld, 0);
    chk("R5 empty top_idx", top_idx, 0);
    chk("R3 empty next_vld", next_vld, 0);
    chk("R5 empty next_idx", next_idx, 0);

    for (int p = 0; p < 256; p++) begin
      int e_top, e_next, cnt;
      @(negedge clk);
      req = 8'(p);
      #1;
      e_top = 0; e_next = 0; cnt = 0;
      for (int b = 0; b < 8; b++) begin
        if (p[b]) begin
          cnt++;
          e_next = e_top;
          e_top = b;
        end
      end
      if (cnt < 2) e_next = 0;
      chk("R1 top_vld", top_vld, cnt >= 1);
      chk("R2 top_idx", top_idx, e_top);
      chk("R3 next_vld", next_vld, cnt >= 2);
      chk("R4 next_idx", next_idx, e_next);
      if (top_vld && next_vld) chk("R6 next below top", next_idx < top_idx, 1);
    end

    @(negedge clk);
    req = 8'b01001001;
    #1;
    chk("R7 example top_idx", top_idx, 6);
    chk("R7 example next_idx", next_idx, 3);
    chk("R7 example flags", {top_vld, next_vld}, 3);

    // R8: changes between clock edges show up at once
    @(posedge clk);
    #1 req = 8'b1000_0000;
    #1 chk("R8 no clock top_idx", top_idx, 7);
    chk("R8 no clock next_vld", next_vld, 0);
    #1 req = 8'b0000_0011;
    #1 chk("R8 no clock top_idx", top_idx, 1);
    chk("R8 no clock next_idx", next_idx, 0);
    chk("R8 no clock next_vld", next_vld, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule